// File: doc/BRIEF.md
# Bus Operation Timeout Watchdog

This block bounds how long a single bus operation issued by one channel may remain outstanding. The bus master presents a level, `opActive`, that is high while its operation is in flight. While that level is high the watchdog counts clock cycles. When the count reaches the configured limit, the block raises a sticky timeout flag. Any other logic may then abort the transfer or raise an interrupt, but that work sits outside this block.

The limit is the product of two powers of two. A 2-bit prescale select chooses how many module clocks make one timeout tick, or it switches the watchdog off. A 3-bit tick select chooses how many ticks are allowed. The prescaler is one free-running counter. The carry out of a selectable low field of that counter advances the tick counter, so no separate divider is needed for each setting. Both counters start again from zero whenever an operation starts, ends, or has its configuration changed. Each operation can raise at most one event. The flag stays set until an explicit clear.

Top module: `busop_timeout_wdt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `timeoutFlag` reads 0.
- R2: Prescale code 1 makes one tick every 2^SHIFT_A clocks, code 2 every 2^SHIFT_B clocks, and code 3 every 2^SHIFT_C clocks. Code 0 is the off setting.
- R3: Tick code t (0 to 7) allows 4·2^t ticks: 4, 8, 16, 32, 64, 128, 256 or 512.
- R4: With a fixed configuration and `opActive` held high, `timeoutFlag` rises on the T-th rising clock edge after the edge that first samples `opActive` high, where T = ticks × prescale.
- R5: While the prescale code is 0, `timeoutFlag` never rises, however long `opActive` stays high.
- R6: When `opActive` is sampled low, counting restarts from zero. If it is low on the edge where the limit would be reached, no event is raised.
- R7: A new operation (a low-to-high change of `opActive`) restarts the count from zero.
- R8: A change of either select while an operation is active restarts the count from zero under the new limit.
- R9: Once set, `timeoutFlag` stays set through the end of the operation and through later operations until it is cleared.
- R10: `flagClr` sampled high on an edge with no new event clears `timeoutFlag` on that edge.
- R11: When a new event and `flagClr` fall on the same edge, the flag ends up set.
- R12: One operation raises at most one event. After a clear, no new event occurs until the count has restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preSel | input | 2 | Prescale code: 0 off, 1/2/3 select the tap |
| tickSel | input | 3 | Tick code t, allowing 4·2^t ticks |
| opActive | input | 1 | High while a bus operation is outstanding |
| flagClr | input | 1 | Clears the timeout flag when sampled high |
| timeoutFlag | output | 1 | Sticky timeout indication |

## Verification
The two functions that can meet in one cycle are a timeout event and the software clear. The bench provokes the collision by holding `flagClr` high for exactly the edge that reaches the limit, then checks that the flag reads set afterwards. A second collision puts the end of an operation on the limit edge itself. The expected result there is no event, because the restart has priority over the fire. Every cycle, a behavioural reference that counts cycles against the ticks × prescale product judges both collisions, along with a set of explicit cycle-count measurements.

// File: rtl/busop_wdt_pkg.sv
package busop_wdt_pkg;

  localparam int unsigned PRE_SEL_W     = 2;
  localparam int unsigned PRE_SEL_N     = 1 << PRE_SEL_W;
  localparam int unsigned TICK_SEL_W    = 3;
  localparam int unsigned TICK_BASE_LOG = 2;
  localparam int unsigned TICK_MAX_LOG  = TICK_BASE_LOG + (1 << TICK_SEL_W) - 1;
  localparam int unsigned TICK_W        = TICK_MAX_LOG + 1;
  localparam int unsigned CFG_W         = PRE_SEL_W + TICK_SEL_W;

  typedef enum logic [PRE_SEL_W-1:0] {
    PRE_OFF  = 2'd0,
    PRE_LOW  = 2'd1,
    PRE_MID  = 2'd2,
    PRE_HIGH = 2'd3
  } preSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;  // return both counters to zero
    logic run;     // advance the prescaler this cycle
  } wdtStrb_t;

endpackage

// File: rtl/busop_wdt_dp.sv
module busop_wdt_dp
  import busop_wdt_pkg::*;
#(
  parameter int unsigned SHIFT_A = 8,
  parameter int unsigned SHIFT_B = 16,
  parameter int unsigned SHIFT_C = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wdtStrb_t              strb,
  input  logic [PRE_SEL_W-1:0]  preSel,
  input  logic [TICK_SEL_W-1:0] tickSel,
  output logic                  limitHit
);

  localparam int unsigned PRE_W = SHIFT_C;

  logic [PRE_W-1:0]     preCnt;
  logic [TICK_W-1:0]    tickCnt;
  logic [TICK_W-1:0]    tickNext;
  logic [TICK_W-1:0]    tickLimit;
  logic [PRE_SEL_N-1:0] carryVec;
  logic                 tickStep;

  // code 0 has no tap; the others watch the carry out of a low field
  assign carryVec[0] = 1'b0;
  for (genvar g = 1; g < PRE_SEL_N; g++) begin : gTap
    localparam int unsigned SH = (g == 1) ? SHIFT_A : ((g == 2) ? SHIFT_B : SHIFT_C);
    assign carryVec[g] = &preCnt[SH-1:0];
  end

  always_comb begin
    tickLimit = TICK_W'(1) << (TICK_BASE_LOG + 32'(tickSel));
    tickStep  = strb.run & carryVec[preSel];
    tickNext  = tickCnt + TICK_W'(1);
    limitHit  = tickStep & (tickNext == tickLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strb.clrCnt) begin
      preCnt <= '0;
    end else if (strb.run) begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.clrCnt) begin
      tickCnt <= '0;
    end else if (tickStep) begin
      tickCnt <= tickNext;
    end
  end

endmodule

// File: rtl/busop_wdt_ctl.sv
module busop_wdt_ctl
  import busop_wdt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PRE_SEL_W-1:0]  preSel,
  input  logic [TICK_SEL_W-1:0] tickSel,
  input  logic                  opActive,
  input  logic                  flagClr,
  input  logic                  limitHit,
  output wdtStrb_t              strb,
  output logic                  timeoutFlag
);

  logic             actQ;
  logic [CFG_W-1:0] cfgQ;
  logic [CFG_W-1:0] cfgNow;
  logic             fired;
  logic             flagQ;
  logic             restart;
  logic             offSel;

  always_comb begin
    cfgNow      = {preSel, tickSel};
    restart     = (opActive != actQ) | (cfgNow != cfgQ);
    offSel      = (preSel_e'(preSel) == PRE_OFF);
    strb.clrCnt = restart | offSel | ~opActive;
    strb.run    = ~strb.clrCnt & ~fired;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ <= 1'b0;
      cfgQ <= '0;
    end else begin
      actQ <= opActive;
      cfgQ <= cfgNow;
    end
  end

  // one event per operation: hold off until the counters restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fired <= 1'b0;
    end else if (strb.clrCnt) begin
      fired <= 1'b0;
    end else if (limitHit) begin
      fired <= 1'b1;
    end
  end

  // a new event takes priority over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (limitHit) begin
      flagQ <= 1'b1;
    end else if (flagClr) begin
      flagQ <= 1'b0;
    end
  end

  assign timeoutFlag = flagQ;

endmodule

// File: rtl/busop_timeout_wdt.sv
module busop_timeout_wdt
  import busop_wdt_pkg::*;
#(
  parameter int unsigned SHIFT_A = 8,
  parameter int unsigned SHIFT_B = 16,
  parameter int unsigned SHIFT_C = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] preSel,
  input  logic [2:0] tickSel,
  input  logic       opActive,
  input  logic       flagClr,
  output logic       timeoutFlag
);

  wdtStrb_t strb;
  logic     limitHit;

  busop_wdt_ctl ctlI (
    .clk        (clk),
    .rstN       (rstN),
    .preSel     (preSel),
    .tickSel    (tickSel),
    .opActive   (opActive),
    .flagClr    (flagClr),
    .limitHit   (limitHit),
    .strb       (strb),
    .timeoutFlag(timeoutFlag)
  );

  busop_wdt_dp #(
    .SHIFT_A(SHIFT_A),
    .SHIFT_B(SHIFT_B),
    .SHIFT_C(SHIFT_C)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .preSel  (preSel),
    .tickSel (tickSel),
    .limitHit(limitHit)
  );

endmodule

// File: rtl/busop_wdt_chk.sv
module busop_wdt_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] preSel,
  input logic       opActive,
  input logic       flagClr,
  input logic       timeoutFlag
);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr) |=> timeoutFlag);

  // R10
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |-> $past(flagClr));

  // R5
  off_never_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> ($past(preSel) != 2'd0));

  // R6
  fire_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> ($past(opActive) && $past(opActive, 2)));

endmodule

bind busop_timeout_wdt busop_wdt_chk chkI (
  .clk        (clk),
  .rstN       (rstN),
  .preSel     (preSel),
  .opActive   (opActive),
  .flagClr    (flagClr),
  .timeoutFlag(timeoutFlag)
);

// File: tb/busop_timeout_wdt_test.sv
module busop_timeout_wdt_test;

  localparam int SA = 2;
  localparam int SB = 3;
  localparam int SC = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] preSel = 2'd0;
  logic [2:0] tickSel = 3'd0;
  logic       opActive = 1'b0;
  logic       flagClr = 1'b0;
  logic       timeoutFlag;

  always #5 clk = ~clk;

  busop_timeout_wdt #(.SHIFT_A(SA), .SHIFT_B(SB), .SHIFT_C(SC)) uut (
    .clk(clk), .rstN(rstN), .preSel(preSel), .tickSel(tickSel),
    .opActive(opActive), .flagClr(flagClr), .timeoutFlag(timeoutFlag)
  );

  int    errs = 0;
  int    checks = 0;
  bit    finished = 0;
  string curReq = "R1";

  // behavioural reference
  bit         mAct = 0;
  logic [4:0] mCfg = '0;
  longint     mCnt = 0;
  bit         mFired = 0;
  bit         mFlag = 0;
  bit         mHit;
  bit         mRestart;

  function automatic longint prescale(int p);
    return (p == 1) ? (longint'(1) << SA) : (p == 2) ? (longint'(1) << SB) :
           (p == 3) ? (longint'(1) << SC) : 0;
  endfunction

  function automatic longint span(int p, int t);
    return prescale(p) * (longint'(4) << t);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mCfg = '0; mCnt = 0; mFired = 0; mFlag = 0;
    end else begin
      mHit = 0;
      mRestart = (opActive != mAct) || ({preSel, tickSel} != mCfg);
      if (mRestart || preSel == 2'd0 || !opActive) begin
        mCnt = 0; mFired = 0;
      end else if (!mFired) begin
        mCnt++;
        if (mCnt == span(int'(preSel), int'(tickSel))) begin
          mFired = 1; mHit = 1;
        end
      end
      if (mHit) mFlag = 1;
      else if (flagClr) mFlag = 0;
      mAct = opActive;
      mCfg = {preSel, tickSel};
    end
  end

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: timeoutFlag=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkNum(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: cycles=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every cycle: compare against the reference
  always @(negedge clk) begin
    if (!finished) checkBit({curReq, " model"}, timeoutFlag, mFlag);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    step(1);
    flagClr = 1'b0;
  endtask

  // returns negedges from rise of opActive until the flag is seen
  task automatic waitFlag(longint lim, output longint k);
    k = 0;
    while (!timeoutFlag && k < lim) begin
      step(1);
      k++;
    end
  endtask

  task automatic measure(string req, int p, int t);
    longint k;
    curReq = req;
    opActive = 1'b0; preSel = 2'(p); tickSel = 3'(t);
    step(2);
    pulseClr();
    step(1);
    opActive = 1'b1;
    waitFlag(span(p, t) + 10, k);
    checkNum(req, k, span(p, t) + 1);
    opActive = 1'b0;
    step(2);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    longint k;
    step(3);
    curReq = "R1";
    checkBit("R1", timeoutFlag, 1'b0);
    rstN = 1'b1;
    step(1);
    checkBit("R1", timeoutFlag, 1'b0);

    // R3: every tick code on the lowest tap
    for (int t = 0; t < 8; t++) measure("R3", 1, t);
    // R2: the other taps
    measure("R2", 2, 0);
    measure("R2", 2, 3);
    measure("R2", 3, 0);
    // R4: longest setting
    measure("R4", 3, 7);

    // R5: off code
    curReq = "R5";
    preSel = 2'd0; tickSel = 3'd0;
    pulseClr();
    opActive = 1'b1;
    step(600);
    checkBit("R5", timeoutFlag, 1'b0);
    opActive = 1'b0;
    step(2);

    // R6: operation ends exactly at the limit edge, then one edge later
    curReq = "R6";
    preSel = 2'd1; tickSel = 3'd0;   // limit 16 cycles
    step(2);
    pulseClr();
    opActive = 1'b1;
    step(16);
    opActive = 1'b0;
    step(3);
    checkBit("R6", timeoutFlag, 1'b0);
    opActive = 1'b1;
    step(17);
    opActive = 1'b0;
    step(1);
    checkBit("R6", timeoutFlag, 1'b1);

    // R7: a new operation restarts from zero
    curReq = "R7";
    pulseClr();
    opActive = 1'b1;
    step(10);
    opActive = 1'b0;
    step(1);
    opActive = 1'b1;
    waitFlag(40, k);
    checkNum("R7", k, 17);
    opActive = 1'b0;
    step(2);

    // R8: config change mid-operation restarts under the new limit
    curReq = "R8";
    pulseClr();
    opActive = 1'b1;
    step(12);
    tickSel = 3'd1;                  // limit 32 cycles
    waitFlag(60, k);
    checkNum("R8", k, 33);

    // R9: sticky through end and a following operation
    curReq = "R9";
    step(20);
    checkBit("R9", timeoutFlag, 1'b1);
    opActive = 1'b0;
    step(5);
    checkBit("R9", timeoutFlag, 1'b1);
    opActive = 1'b1;
    step(5);
    checkBit("R9", timeoutFlag, 1'b1);
    opActive = 1'b0;
    step(2);

    // R10: clear pulse
    curReq = "R10";
    pulseClr();
    checkBit("R10", timeoutFlag, 1'b0);

    // R11: event and clear on the same edge
    curReq = "R11";
    tickSel = 3'd0;
    step(2);
    opActive = 1'b1;
    step(16);
    flagClr = 1'b1;
    step(1);
    flagClr = 1'b0;
    checkBit("R11", timeoutFlag, 1'b1);

    // R12: no second event for the same operation
    curReq = "R12";
    pulseClr();
    step(48);
    checkBit("R12", timeoutFlag, 1'b0);
    opActive = 1'b0;
    step(3);

    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run did not end, expected completion");
      finishRun();
    end
  end

endmodule